// File: doc/BRIEF.md
# Phase-Encoded Link Transmitter

This block drives a parallel word onto a wire bundle meant for a self-timed link. The bundle has one shared reference pair and one symbol pair per data bit. Every accepted word moves the reference pair one step around a four-state Gray cycle. Each symbol pair then shows the new reference state or its bitwise complement. A matching symbol encodes a 0 and a complemented one encodes a 1. The receiver works out each bit from the phase of its symbol relative to the reference. It needs no separate valid wire.

The sender presents a word together with a one-cycle valid strobe. The block registers the reference and every symbol on the same clock edge, so the wires change together and carry no combinational glitches. When the strobe is low, the data input is ignored and the link holds its state.

Top module: `phase_link_tx`

## Requirements
- R1: While reset is high at a clock edge, the reference pair becomes 00 and every symbol pair becomes 00.
- R2: Each edge with the valid strobe high moves the reference pair one step around the cycle 00 -> 01 -> 11 -> 10 -> 00. Bit 1 of `ref_o` is the first digit written.
- R3: At an edge with the valid strobe low, the reference and all symbols keep their values, whatever the data input holds.
- R4: For a data bit of 0, the symbol pair `sym_o[2i+1:2i]` for bit i equals the new reference value.
- R5: For a data bit of 1, the symbol pair for that bit equals the bitwise complement of the new reference value.
- R6: For each accepted word, the reference pair and each symbol pair change in exactly one wire, whatever the old and new data.
- R7: The reference and all symbols take their new values on the same clock edge that samples the valid strobe. They are visible one register stage after the inputs.
- R8: The data width is set by the parameter `DATA_W` (default 4). The link is 2*DATA_W+2 wires wide.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_i | input | DATA_W | Data word to send |
| word_vld_i | input | 1 | Word strobe; high for one cycle per word |
| ref_o | output | 2 | Reference pair |
| sym_o | output | 2*DATA_W | Symbol pairs; bit i uses [2i+1:2i] |

## Verification
Two functions of this block can fall in the same cycle: the Gray step of the reference and a change of a bit's phase. When a bit flips between two accepted words, its symbol must both follow the reference step and swap phase. The bench provokes this with alternating patterns such as 0xA, 0x5, 0x0 and 0xF, sent back to back and across the 10 -> 00 wrap. It judges each result against a scoreboard model and also counts the wires that changed in each pair, which must be exactly one.

// File: rtl/phase_link_pkg.sv
package phase_link_pkg;

   typedef logic [1:0] pair_t;

   // One step around the cycle 00 -> 01 -> 11 -> 10 -> 00
   function automatic pair_t gray_step(input pair_t cur);
      return {cur[0], ~cur[1]};
   endfunction

endpackage

// File: rtl/gray_ref_gen.sv
module gray_ref_gen
   import phase_link_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  adv_i,
   output pair_t ref_q_o,
   output pair_t ref_nxt_o
);

   pair_t ref_q;

   assign ref_nxt_o = gray_step(ref_q);
   assign ref_q_o   = ref_q;

   always_ff @(posedge clk) begin
      if (rst)
         ref_q <= '0;
      else if (adv_i)
         ref_q <= ref_nxt_o;
   end

   // R2
   ref_one_step_chk: assert property (@(posedge clk) disable iff (rst)
      adv_i |=> ($countones(ref_q ^ $past(ref_q)) == 1));

   // R3
   ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !adv_i |=> $stable(ref_q));

endmodule

// File: rtl/phase_sym_cell.sv
module phase_sym_cell
   import phase_link_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  load_i,
   input  logic  bit_i,
   input  pair_t ref_nxt_i,
   input  pair_t ref_q_i,
   output pair_t sym_o
);

   pair_t sym_q;
   pair_t sym_d;

   assign sym_d = ref_nxt_i ^ {2{bit_i}};
   assign sym_o = sym_q;

   always_ff @(posedge clk) begin
      if (rst)
         sym_q <= '0;
      else if (load_i)
         sym_q <= sym_d;
   end

   // R4 R5
   sym_phase_chk: assert property (@(posedge clk) disable iff (rst)
      load_i |=> (sym_q == ($past(bit_i) ? ~ref_q_i : ref_q_i)));

   // R6
   sym_one_wire_chk: assert property (@(posedge clk) disable iff (rst)
      load_i |=> ($countones(sym_q ^ $past(sym_q)) == 1));

   // R3
   sym_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> $stable(sym_q));

endmodule

// File: rtl/phase_link_tx.sv
module phase_link_tx
   import phase_link_pkg::*;
#(
   parameter int DATA_W = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [DATA_W-1:0]   word_i,
   input  logic                word_vld_i,
   output logic [1:0]          ref_o,
   output logic [2*DATA_W-1:0] sym_o
);

   localparam int SYM_W  = 2 * DATA_W;
   localparam int LINK_W = SYM_W + 2;

   if (DATA_W < 1) begin : g_bad_width
      $error("phase_link_tx: DATA_W must be at least 1");
   end
   if (LINK_W != 2 * (DATA_W + 1)) begin : g_bad_link
      $error("phase_link_tx: link width derivation broken");
   end

   pair_t ref_q;
   pair_t ref_nxt;

   gray_ref_gen u_ref (
      .clk       (clk),
      .rst       (rst),
      .adv_i     (word_vld_i),
      .ref_q_o   (ref_q),
      .ref_nxt_o (ref_nxt)
   );

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
      pair_t cell_sym;
      phase_sym_cell u_cell (
         .clk       (clk),
         .rst       (rst),
         .load_i    (word_vld_i),
         .bit_i     (word_i[gi]),
         .ref_nxt_i (ref_nxt),
         .ref_q_i   (ref_q),
         .sym_o     (cell_sym)
      );
      assign sym_o[2*gi +: 2] = cell_sym;
   end

   assign ref_o = ref_q;

   // R1
   reset_zero_chk: assert property (@(posedge clk)
      rst |=> (ref_o == 2'b00 && sym_o == '0));

   // R7
   same_edge_chk: assert property (@(posedge clk) disable iff (rst)
      word_vld_i |=> (ref_o != $past(ref_o) && sym_o != $past(sym_o)));

endmodule

// File: tb/phase_link_tx_tb_top.sv
module phase_link_tx_tb_top;

   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] word = '0;
   logic         vld = 1'b0;
   logic [1:0]   ref_w;
   logic [2*W-1:0] sym_w;

   always #10 clk = ~clk;

   phase_link_tx #(.DATA_W(W)) dut_i (
      .clk        (clk),
      .rst        (rst),
      .word_i     (word),
      .word_vld_i (vld),
      .ref_o      (ref_w),
      .sym_o      (sym_w)
   );

   typedef struct {
      logic [1:0]     r;
      logic [2*W-1:0] s;
      bit             adv;
      string          req;
   } exp_t;

   exp_t q[$];
   int   n_vec = 0;
   int   n_bad = 0;
   logic [1:0]     m_ref = 2'b00;
   logic [2*W-1:0] m_sym = '0;
   logic [1:0]     prev_ref = 2'b00;
   logic [2*W-1:0] prev_sym = '0;
   bit   done = 0;

   function automatic logic [1:0] next_state(input logic [1:0] c);
      case (c)
         2'b00:   return 2'b01;
         2'b01:   return 2'b11;
         2'b11:   return 2'b10;
         default: return 2'b00;
      endcase
   endfunction

   task automatic push(input bit adv, input string req);
      exp_t e;
      e.r = m_ref; e.s = m_sym; e.adv = adv; e.req = req;
      q.push_back(e);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; vld = 1'b0; word = 4'h9;
      m_ref = 2'b00; m_sym = '0;
      push(0, "R1");
   endtask

   task automatic send(input logic [W-1:0] d, input bit v, input string req);
      @(negedge clk);
      rst = 1'b0; word = d; vld = v;
      if (v) begin
         m_ref = next_state(m_ref);
         for (int i = 0; i < W; i++)
            m_sym[2*i +: 2] = d[i] ? ~m_ref : m_ref;
      end
      push(v, req);
   endtask

   // monitor: compare results after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (ref_w !== e.r || sym_w !== e.s) begin
               n_bad++;
               $display("FAIL %s: ref=%b sym=%b expected ref=%b sym=%b",
                        e.req, ref_w, sym_w, e.r, e.s);
            end
            if (e.adv) begin
               n_vec++;
               if ($countones(ref_w ^ prev_ref) != 1) begin
                  n_bad++;
                  $display("FAIL R6: ref changed %b -> %b, expected one wire",
                           prev_ref, ref_w);
               end
               for (int i = 0; i < W; i++) begin
                  if ($countones(sym_w[2*i +: 2] ^ prev_sym[2*i +: 2]) != 1) begin
                     n_bad++;
                     $display("FAIL R6: pair %0d %b -> %b, expected one wire",
                              i, prev_sym[2*i +: 2], sym_w[2*i +: 2]);
                  end
               end
            end
            prev_ref = ref_w;
            prev_sym = sym_w;
         end
      end
   end

   // driver
   initial begin
      do_reset();
      do_reset();
      // R2 R4: all zero data, full cycle plus wrap
      for (int k = 0; k < 5; k++) send(4'h0, 1, "R2");
      // R5: all ones
      for (int k = 0; k < 4; k++) send(4'hF, 1, "R5");
      // R3: strobe low, data wiggles
      send(4'h3, 0, "R3");
      send(4'hC, 0, "R3");
      send(4'h6, 0, "R3");
      // R6 R7: phase flips together with the Gray step, back to back
      send(4'hA, 1, "R7");
      send(4'h5, 1, "R6");
      send(4'h0, 1, "R6");
      send(4'hF, 1, "R6");
      send(4'hA, 1, "R4");
      send(4'h5, 1, "R5");
      // gaps between words
      send(4'h9, 1, "R7");
      send(4'h6, 0, "R3");
      send(4'h6, 1, "R7");
      // R8: every bit position individually
      for (int k = 0; k < W; k++) send(4'(1 << k), 1, "R8");
      for (int k = 0; k < 24; k++) send(4'($urandom), 1'($urandom), "R2");
      // reset in the middle of traffic
      do_reset();
      send(4'h7, 1, "R4");
      send(4'h7, 0, "R3");
      @(negedge clk);
      vld = 1'b0;
      repeat (3) @(negedge clk);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (200000) @(posedge clk);
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule